// File: doc/BRIEF.md
# Timer Compare Channel

An 8-bit timer/counter with one compare channel and a single waveform output bit. A plain register write port lets software load the counter and the compare value. Through the same port it selects the counting mode and the output action, fires a forced compare, and clears the match flag. The counter moves only on cycles where the timer enable pulse is high, so any prescaler sits outside the block.

Four counting modes exist: free-running, clear-on-match, single-slope PWM and dual-slope PWM. In the two PWM modes the compare value is staged in a shadow register and only reaches the comparator at a fixed point of the count. This keeps each PWM period internally consistent. In the other two modes compare writes take effect at once.

The write port has no back-pressure: every write is accepted in the cycle it is presented, so it needs no valid/ready pair. All other pins are plain level signals.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the counter, the active compare value, the flag and the output bit are all 0. The mode is free-running (mode 0), the output action is "keep" (code 0), and the count direction is up.
- R2: The counter changes only on a cycle with the enable pulse, or on a write to address 0, which loads the written value. In free-running mode it counts up and wraps from 0xFF to 0x00.
- R3: In clear-on-match mode (mode 1), an enable pulse while the counter equals the active compare value and no block is pending returns the counter to 0.
- R4: In dual-slope mode (mode 3), the counter counts up to 0xFF. An enable pulse at 0xFF turns it downward. It then counts down to 0x00, and an enable pulse at 0x00 turns it upward again.
- R5: In modes 0 and 1, a write to address 1 changes the active compare value at the next clock edge.
- R6: In modes 2 and 3, a write to address 1 fills the shadow register only. The active value takes the shadow content on an enable pulse while the counter is 0xFF. In mode 2 this is the roll to 0x00; in mode 3 it is the turn at the top.
- R7: A real match is an enable pulse with the counter equal to the active value and no block pending. It sets the flag and applies the action held in bits [3:2] of address 2 to the output bit: 0 keep, 1 toggle, 2 clear, 3 set. A change of the action bits applies to the very next match. Bits [1:0] of address 2 hold the mode.
- R8: In mode 2, the roll from 0xFF to 0x00 applies the mirror action: set for code 2, clear for code 3, nothing otherwise. In mode 3, a match while counting down applies that same mirror action.
- R9: Writing 1 to bit 0 of address 3 in modes 0 and 1 applies the action to the output bit without setting the flag or touching the counter. In modes 2 and 3 it has no effect.
- R10: A counter write cancels the enable pulse of its own cycle. It also suppresses any match on the next enable pulse, however many cycles later that pulse comes.
- R11: Writing 1 to bit 1 of address 3 clears the flag, unless a real match occurs in the same cycle, in which case the flag stays set.
- R12: The output bit keeps its value when the mode or the action bits change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer enable pulse; one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 counter, 1 compare, 2 control, 3 command |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| cmp_o | output | 8 | Active compare value seen by the comparator |
| flag_o | output | 1 | Compare match flag |
| oc_o | output | 1 | Waveform output bit |

## Verification
A flag-clear command and a real match can land in the same cycle. The bench provokes this by issuing the clear while an enable pulse finds the counter equal to the compare value, and it expects the flag to remain set. Only a later clear with no match present may drop it. In a separate cycle, a counter write is paired with an enable pulse. The counter must hold the written value rather than the incremented one, and the match on the following pulse must be suppressed.

// File: rtl/tmr_cmp_pkg.sv
`timescale 1ns/1ps
package tmr_cmp_pkg;

  typedef enum logic [1:0] {
    WG_FREE  = 2'd0,
    WG_CLR   = 2'd1,
    WG_FAST  = 2'd2,
    WG_PHASE = 2'd3
  } wg_mode_e;

  typedef enum logic [1:0] {
    OC_KEEP   = 2'd0,
    OC_TOGGLE = 2'd1,
    OC_CLEAR  = 2'd2,
    OC_SET    = 2'd3
  } oc_act_e;

  localparam logic [1:0] REG_CNT = 2'd0;
  localparam logic [1:0] REG_CMP = 2'd1;
  localparam logic [1:0] REG_CTL = 2'd2;
  localparam logic [1:0] REG_CMD = 2'd3;

  function automatic logic is_pwm(input wg_mode_e m);
    return m == WG_FAST || m == WG_PHASE;
  endfunction

  function automatic oc_act_e oc_mirror(input oc_act_e a);
    case (a)
      OC_CLEAR: return OC_SET;
      OC_SET:   return OC_CLEAR;
      default:  return OC_KEEP;
    endcase
  endfunction

  function automatic logic oc_apply(input oc_act_e a, input logic cur);
    case (a)
      OC_TOGGLE: return ~cur;
      OC_CLEAR:  return 1'b0;
      OC_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_cmp_counter.sv
`timescale 1ns/1ps
module tmr_cmp_counter
  import tmr_cmp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          ld_en_i,
  input  logic [CW-1:0] ld_val_i,
  input  wg_mode_e      mode_i,
  input  logic          ctc_hit_i,
  output logic [CW-1:0] cnt_o,
  output logic          down_o
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (mode_i != WG_PHASE) down_q <= 1'b0;
      if (ld_en_i) begin
        cnt_q <= ld_val_i;
      end else if (adv_i) begin
        case (mode_i)
          WG_CLR: cnt_q <= ctc_hit_i ? '0 : cnt_q + ONE;
          WG_PHASE: begin
            if (!down_q) begin
              if (cnt_q == MAXV) begin
                down_q <= 1'b1;
                cnt_q  <= cnt_q - ONE;
              end else begin
                cnt_q <= cnt_q + ONE;
              end
            end else if (cnt_q == '0) begin
              down_q <= 1'b0;
              cnt_q  <= cnt_q + ONE;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          default: cnt_q <= cnt_q + ONE;
        endcase
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !ld_en_i) |=> $stable(cnt_q));

  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |=> cnt_q == $past(ld_val_i));

  assert_phase_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == WG_PHASE && adv_i && !ld_en_i && !down_q && cnt_q == MAXV) |=> down_q);

endmodule

// File: rtl/tmr_cmp_compare.sv
`timescale 1ns/1ps
module tmr_cmp_compare #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          flag_clr_i,
  input  logic          pwm_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cmp_o,
  output logic          flag_o,
  output logic          match_o,
  output logic          top_o
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [CW-1:0] shadow_q;
  logic [CW-1:0] active_q;
  logic          blk_q;
  logic          flag_q;
  logic          adv;
  logic          load;

  assign adv     = tick_i && !cnt_wr_i;
  assign match_o = adv && !blk_q && (cnt_i == active_q);
  assign top_o   = adv && (cnt_i == MAXV);
  assign load    = pwm_i && top_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      blk_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (cnt_wr_i)    blk_q <= 1'b1;
      else if (tick_i) blk_q <= 1'b0;

      if (cmp_wr_i) shadow_q <= wdata_i;

      if (cmp_wr_i && !pwm_i) active_q <= wdata_i;
      else if (load)          active_q <= shadow_q;

      if (match_o)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cmp_o  = active_q;
  assign flag_o = flag_q;

  assert_direct_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_i && !pwm_i) |=> active_q == $past(wdata_i));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_i && !(tick_i && !cnt_wr_i && cnt_i == MAXV)) |=> $stable(active_q));

  assert_blocked_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick_i && !flag_q) |=> !flag_q);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !match_o) |=> !flag_q);

endmodule

// File: rtl/tmr_cmp_wavegen.sv
`timescale 1ns/1ps
module tmr_cmp_wavegen
  import tmr_cmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wg_mode_e mode_i,
  input  oc_act_e  act_i,
  input  logic     match_i,
  input  logic     top_i,
  input  logic     down_i,
  input  logic     force_i,
  output logic     oc_o
);
  logic    oc_q;
  oc_act_e eff;
  logic    pwm;

  assign pwm = is_pwm(mode_i);

  always_comb begin
    eff = OC_KEEP;
    if (match_i)
      eff = (mode_i == WG_PHASE && down_i) ? oc_mirror(act_i) : act_i;
    else if (force_i && !pwm)
      eff = act_i;
    if (mode_i == WG_FAST && top_i && oc_mirror(act_i) != OC_KEEP)
      eff = oc_mirror(act_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_apply(eff, oc_q);
  end

  assign oc_o = oc_q;

  assert_force_pwm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && pwm && !match_i && !top_i) |=> $stable(oc_q));

  assert_oc_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_i && !top_i && !force_i) |=> $stable(oc_q));

endmodule

// File: rtl/tmr_cmp_unit.sv
`timescale 1ns/1ps
module tmr_cmp_unit
  import tmr_cmp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cmp_o,
  output logic          flag_o,
  output logic          oc_o
);
  wg_mode_e mode_q;
  oc_act_e  act_q;

  logic cnt_wr, cmp_wr, ctl_wr, cmd_wr;
  logic force_req, flag_clr;
  logic match, top, down;
  logic [CW-1:0] cnt;

  assign cnt_wr    = wr_en_i && wr_addr_i == REG_CNT;
  assign cmp_wr    = wr_en_i && wr_addr_i == REG_CMP;
  assign ctl_wr    = wr_en_i && wr_addr_i == REG_CTL;
  assign cmd_wr    = wr_en_i && wr_addr_i == REG_CMD;
  assign force_req = cmd_wr && wr_data_i[0];
  assign flag_clr  = cmd_wr && wr_data_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WG_FREE;
      act_q  <= OC_KEEP;
    end else if (ctl_wr) begin
      mode_q <= wg_mode_e'(wr_data_i[1:0]);
      act_q  <= oc_act_e'(wr_data_i[3:2]);
    end
  end

  tmr_cmp_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (tick_i && !cnt_wr),
    .ld_en_i   (cnt_wr),
    .ld_val_i  (wr_data_i),
    .mode_i    (mode_q),
    .ctc_hit_i (match),
    .cnt_o     (cnt),
    .down_o    (down)
  );

  tmr_cmp_compare #(.CW(CW)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cnt_wr_i   (cnt_wr),
    .cmp_wr_i   (cmp_wr),
    .wdata_i    (wr_data_i),
    .flag_clr_i (flag_clr),
    .pwm_i      (is_pwm(mode_q)),
    .cnt_i      (cnt),
    .cmp_o      (cmp_o),
    .flag_o     (flag_o),
    .match_o    (match),
    .top_o      (top)
  );

  tmr_cmp_wavegen u_wav (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_q),
    .act_i   (act_q),
    .match_i (match),
    .top_i   (top),
    .down_i  (down),
    .force_i (force_req),
    .oc_o    (oc_o)
  );

  assign cnt_o = cnt;

  assert_ctc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WG_CLR && match && !cnt_wr) |=> cnt_o == '0);

  assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_o);

endmodule

// File: tb/tmr_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [7:0] cnt_o, cmp_o;
  logic       flag_o, oc_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tmr_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cnt_o(cnt_o), .cmp_o(cmp_o), .flag_o(flag_o), .oc_o(oc_o)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] a;
    logic [7:0] d;
    logic       tk;
    logic [7:0] cnt;
    logic [7:0] cmp;
    logic       fl;
    logic       oc;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd2, 8'h04, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 toggle action
    '{1'b1, 2'd1, 8'h03, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0, 4'd5},  // R5 direct compare
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 8'h03, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h02, 8'h03, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b0, 8'h02, 8'h03, 1'b0, 1'b0, 4'd2},  // R2 hold
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h03, 8'h03, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h04, 8'h03, 1'b1, 1'b1, 4'd7},  // R7 match
    '{1'b1, 2'd3, 8'h02, 1'b0, 8'h04, 8'h03, 1'b0, 1'b1, 4'd11}, // R11
    '{1'b1, 2'd2, 8'h08, 1'b0, 8'h04, 8'h03, 1'b0, 1'b1, 4'd7},
    '{1'b1, 2'd0, 8'h03, 1'b0, 8'h03, 8'h03, 1'b0, 1'b1, 4'd10}, // R10
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h04, 8'h03, 1'b0, 1'b1, 4'd10}, // blocked
    '{1'b1, 2'd0, 8'h03, 1'b0, 8'h03, 8'h03, 1'b0, 1'b1, 4'd10},
    '{1'b0, 2'd0, 8'h00, 1'b0, 8'h03, 8'h03, 1'b0, 1'b1, 4'd10},
    '{1'b0, 2'd0, 8'h00, 1'b0, 8'h03, 8'h03, 1'b0, 1'b1, 4'd10},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h04, 8'h03, 1'b0, 1'b1, 4'd10}, // block survives idle
    '{1'b1, 2'd0, 8'hFE, 1'b0, 8'hFE, 8'h03, 1'b0, 1'b1, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'hFF, 8'h03, 1'b0, 1'b1, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 8'h03, 1'b0, 1'b1, 4'd2},  // R2 wrap
    '{1'b1, 2'd0, 8'h02, 1'b0, 8'h02, 8'h03, 1'b0, 1'b1, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h03, 8'h03, 1'b0, 1'b1, 4'd10},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h04, 8'h03, 1'b1, 1'b0, 4'd7},  // clear action
    '{1'b1, 2'd3, 8'h01, 1'b0, 8'h04, 8'h03, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 2'd2, 8'h0C, 1'b0, 8'h04, 8'h03, 1'b1, 1'b0, 4'd7},
    '{1'b1, 2'd3, 8'h01, 1'b0, 8'h04, 8'h03, 1'b1, 1'b1, 4'd9},
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h05, 8'h03, 1'b1, 1'b1, 4'd2}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d, input logic tk);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; tick_i = tk;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_o, 8'h00);
    chk("R1 cmp", cmp_o, 8'h00);
    chk("R1 flag", {7'd0, flag_o}, 8'h00);
    chk("R1 oc", {7'd0, oc_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].we, TBL[i].a, TBL[i].d, TBL[i].tk);
      chk($sformatf("R%0d row%0d cnt", TBL[i].rq, i), cnt_o, TBL[i].cnt);
      chk($sformatf("R%0d row%0d cmp", TBL[i].rq, i), cmp_o, TBL[i].cmp);
      chk($sformatf("R%0d row%0d flag", TBL[i].rq, i), {7'd0, flag_o}, {7'd0, TBL[i].fl});
      chk($sformatf("R%0d row%0d oc", TBL[i].rq, i), {7'd0, oc_o}, {7'd0, TBL[i].oc});
    end

    // R10: counter write with a pulse in the same cycle; R11 clear versus match
    step(1'b1, 2'd1, 8'h08, 1'b0);
    step(1'b1, 2'd0, 8'h07, 1'b1);
    chk("R10 write beats pulse", cnt_o, 8'h07);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R10 count after write", cnt_o, 8'h08);
    step(1'b1, 2'd3, 8'h02, 1'b1);
    chk("R11 match keeps flag", {7'd0, flag_o}, 8'h01);
    chk("R11 count moved", cnt_o, 8'h09);
    step(1'b1, 2'd3, 8'h02, 1'b0);
    chk("R11 flag cleared", {7'd0, flag_o}, 8'h00);

    // R3 clear-on-match mode with toggle action; oc is 1 here
    step(1'b1, 2'd2, 8'h05, 1'b0);
    step(1'b1, 2'd1, 8'h02, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R3 reach compare", cnt_o, 8'h02);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R3 cleared to zero", cnt_o, 8'h00);
    chk("R3 oc toggled", {7'd0, oc_o}, 8'h00);
    chk("R3 flag", {7'd0, flag_o}, 8'h01);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R3 restart", cnt_o, 8'h01);

    // R9 force in free-running mode; R12 output holds across mode changes
    step(1'b1, 2'd3, 8'h02, 1'b0);
    step(1'b1, 2'd2, 8'h0C, 1'b0);
    step(1'b1, 2'd3, 8'h01, 1'b0);
    chk("R9 force sets oc", {7'd0, oc_o}, 8'h01);
    chk("R9 force no flag", {7'd0, flag_o}, 8'h00);
    chk("R9 force no count", cnt_o, 8'h01);
    step(1'b1, 2'd2, 8'h03, 1'b0);
    chk("R12 to dual-slope", {7'd0, oc_o}, 8'h01);
    step(1'b1, 2'd2, 8'h02, 1'b0);
    chk("R12 to single-slope", {7'd0, oc_o}, 8'h01);
    step(1'b1, 2'd2, 8'h08, 1'b0);
    chk("R12 to free", {7'd0, oc_o}, 8'h01);
    step(1'b1, 2'd3, 8'h01, 1'b0);
    chk("R9 force clears oc", {7'd0, oc_o}, 8'h00);

    // R4 R6 R8 dual-slope, clear on up-match
    step(1'b1, 2'd2, 8'h0B, 1'b0);
    step(1'b1, 2'd1, 8'h10, 1'b0);
    chk("R6 shadowed write", cmp_o, 8'h02);
    step(1'b1, 2'd0, 8'hFD, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R4 at top", cnt_o, 8'hFF);
    chk("R6 not yet loaded", cmp_o, 8'h02);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R4 turned down", cnt_o, 8'hFE);
    chk("R6 loaded at top", cmp_o, 8'h10);
    step(1'b1, 2'd0, 8'h12, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R4 counting down", cnt_o, 8'h10);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R8 down match sets", {7'd0, oc_o}, 8'h01);
    chk("R7 down match flag", {7'd0, flag_o}, 8'h01);
    chk("R4 below match", cnt_o, 8'h0F);
    step(1'b1, 2'd0, 8'h01, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R4 bottom", cnt_o, 8'h00);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R4 turned up", cnt_o, 8'h01);
    for (int k = 0; k < 15; k++) step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R4 climbing", cnt_o, 8'h10);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R8 up match clears", {7'd0, oc_o}, 8'h00);
    chk("R4 past match", cnt_o, 8'h11);

    // R6 R8 single-slope, clear action
    step(1'b1, 2'd2, 8'h0A, 1'b0);
    step(1'b1, 2'd1, 8'h05, 1'b0);
    chk("R6 fast shadowed", cmp_o, 8'h10);
    step(1'b1, 2'd0, 8'hFE, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R6 fast loaded at roll", cmp_o, 8'h05);
    chk("R8 roll sets oc", {7'd0, oc_o}, 8'h01);
    chk("R2 roll to zero", cnt_o, 8'h00);
    for (int k = 0; k < 5; k++) step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R6 fast at compare", cnt_o, 8'h05);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R8 fast match clears", {7'd0, oc_o}, 8'h00);
    step(1'b1, 2'd2, 8'h0E, 1'b0);
    step(1'b1, 2'd3, 8'h01, 1'b0);
    chk("R9 force ignored in PWM", {7'd0, oc_o}, 8'h00);
    chk("R9 count untouched", cnt_o, 8'h06);

    summary();
    $finish;
  end

endmodule